// File: doc/BRIEF.md
# Multi-channel ADC scan sequencer

This block steps an external successive-approximation converter through scans of up to sixteen analog channels. A sixteen-bit enable mask selects the channels. Each channel has its own configuration word that gives its mux addresses, single-ended or differential wiring, which of four global aperture times it uses, and whether it is averaged. For each visited channel the sequencer drives the mux addresses and the differential flag. It holds a sample phase for the selected aperture, issues a one-cycle conversion start, and then waits for the converter's done strobe.

Scans are started by a firmware pulse, by a rising edge or a high level on a hardware trigger, or run back to back in continuous mode. A trigger that arrives while a scan is running raises a collision pulse and is replayed as soon as that scan ends. A channel in sequential averaging mode is converted several times in a row. In interleaved mode every channel is converted once per scan. The converter itself and all result arithmetic live outside this block.

Top module: `adc_scan_seq`

## Requirements
- R1: Only channels whose bit is set in `chan_en_i` (bit i = channel i) are converted, in ascending index order within a scan; `chan_o` gives the channel being processed.
- R2: While a channel is processed, `pos_addr_o` equals config bits [11:8] and `diff_o` equals config bit 2. `neg_addr_o` is 0 for a single-ended channel (bit 2 = 0). For an unpaired differential channel (bit 2 = 1, bit 3 = 0) it equals config bits [15:12].
- R3: The sample phase (`sample_o` high) lasts one cycle less than the selected aperture value. Aperture values 0 and 1 give a single sample cycle. The phase is followed by exactly one cycle of `conv_start_o`, and the block then waits for `conv_done_i`.
- R4: Config bits [1:0] pick one of four 10-bit aperture fields in `apt_time_i`; field k sits at bits [10k+9:10k].
- R5: A `fw_start_i` pulse with `cont_i` low converts each enabled channel once. It then pulses `eos_o` for one cycle in the cycle after the last `conv_done_i`, and `busy_o` falls in that same cycle. Out of reset the block is idle, and `busy_o`, `eos_o`, `conv_start_o` and `collision_o` are low.
- R6: A `fw_start_i` pulse with `cont_i` high starts scans back to back. While this mode runs, further start pulses raise no collision. A `fw_stop_i` pulse lets the running scan finish and starts no new one.
- R7: A firmware start, or a hardware edge in edge mode, that arrives during a non-continuous scan pulses `collision_o` once and starts one more scan straight after the current one ends.
- R8: With `trig_mode_i` = 1 (edge), a rising edge of `hw_trig_i` starts exactly one scan, however long the input then stays high.
- R9: With `trig_mode_i` = 2 (level), scans repeat while `hw_trig_i` is high. The scan in progress when the input falls completes, and no further scan starts.
- R10: With `trig_mode_i` = 0 (firmware only), `hw_trig_i` has no effect.
- R11: A channel with config bit 4 set is converted 2<<`avg_log2_i` times back to back when `avg_ilv_i` is low. It is converted once per scan when `avg_ilv_i` is high. Channels with bit 4 clear are converted once.
- R12: For a paired differential channel (bits 2 and 3 set), `neg_addr_o` is `pos_addr_o` with bit 0 set, and config bits [15:12] are ignored.
- R13: A scan started with an all-zero mask pulses `eos_o` in the next cycle without raising `busy_o` or `conv_start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_en_i | input | NCH | Channel enable mask |
| chan_cfg_i | input | NCH*CFG_W | Per-channel configuration words, channel i at [16i+15:16i] |
| apt_time_i | input | 4*APT_W | Four aperture times in clock cycles |
| avg_log2_i | input | AVG_W | Averaging count exponent, count = 2<<value |
| avg_ilv_i | input | 1 | Interleaved averaging (one conversion per scan) |
| trig_mode_i | input | 2 | 0 firmware only, 1 hardware edge, 2 hardware level |
| fw_start_i | input | 1 | Firmware start pulse |
| fw_stop_i | input | 1 | Firmware stop pulse for continuous mode |
| cont_i | input | 1 | Continuous mode select, sampled with the start pulse |
| hw_trig_i | input | 1 | Hardware trigger |
| conv_done_i | input | 1 | Converter done strobe |
| conv_start_o | output | 1 | One-cycle conversion start |
| sample_o | output | 1 | Sample phase active |
| chan_o | output | log2(NCH) | Current channel |
| pos_addr_o | output | ADDR_W | Positive mux address |
| neg_addr_o | output | ADDR_W | Negative mux address |
| diff_o | output | 1 | Differential conversion |
| busy_o | output | 1 | Scan in progress |
| eos_o | output | 1 | End-of-scan pulse |
| collision_o | output | 1 | Trigger-during-scan pulse |

## Verification
The bench targets the boundary cycle where one scan ends and another may begin. If the deferred start is dropped, the bench sees one end-of-scan too few. If a continuous stop cuts a scan short, conversions go missing from the expected list. If level mode stops at the first scan or runs past the falling input, the scan count is wrong. Aperture values 0 and 1 are exercised, and an off-by-one sample counter shows up as a mismatched sample length. The bench also covers an all-zero mask, where a design that starts the converter anyway produces an unexpected conversion. It covers a paired channel with a non-zero negative field, where a design that reads that field shows the wrong negative address. It covers averaging repeat counts in both orderings.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  // config word field positions
  localparam int APT_SEL_LSB = 0;
  localparam int DIFF_BIT    = 2;
  localparam int PAIR_BIT    = 3;
  localparam int AVG_BIT     = 4;
  localparam int POS_LSB     = 8;

  localparam logic [1:0] TRG_FW    = 2'd0;
  localparam logic [1:0] TRG_EDGE  = 2'd1;
  localparam logic [1:0] TRG_LEVEL = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_START  = 2'd2,
    ST_WAIT   = 2'd3
  } scan_st_e;
endpackage

// File: rtl/scan_next_chan.sv
module scan_next_chan #(
  parameter int NCH = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask_i,
  input  logic [CHW:0]   from_i,
  output logic           found_o,
  output logic [CHW-1:0] idx_o
);
  // lowest enabled index at or above from_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i] && ((CHW+1)'(i) >= from_i)) begin
        found_o = 1'b1;
        idx_o   = CHW'(i);
      end
    end
  end
endmodule

// File: rtl/scan_dwell_timer.sv
module scan_dwell_timer #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         en_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= val_i;
    else if (en_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/scan_trig_ctrl.sv
module scan_trig_ctrl
  import adc_scan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] trig_mode_i,
  input  logic       fw_start_i,
  input  logic       fw_stop_i,
  input  logic       cont_i,
  input  logic       hw_trig_i,
  input  logic       busy_i,
  input  logic       scan_end_i,
  output logic       idle_go_o,
  output logic       restart_o,
  output logic       collision_o
);
  logic hw_q, pend_q, cont_q, coll_q;
  logic rise, lvl, evt, cont_live, clash;

  assign rise      = (trig_mode_i == TRG_EDGE) & hw_trig_i & ~hw_q;
  assign lvl       = (trig_mode_i == TRG_LEVEL) & hw_trig_i;
  assign evt       = fw_start_i | rise;
  assign cont_live = cont_q & ~fw_stop_i;
  // triggers during a one-shot scan collide; continuous mode swallows them
  assign clash     = busy_i & evt & ~cont_q;

  assign idle_go_o   = evt | lvl | cont_live;
  assign restart_o   = pend_q | cont_live | lvl | clash;
  assign collision_o = coll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_q   <= 1'b0;
      pend_q <= 1'b0;
      cont_q <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      hw_q   <= hw_trig_i;
      coll_q <= clash;
      if (scan_end_i)  pend_q <= 1'b0;
      else if (clash)  pend_q <= 1'b1;
      if (fw_stop_i)                 cont_q <= 1'b0;
      else if (fw_start_i && cont_i) cont_q <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int APT_W  = 10,
  parameter int ADDR_W = 4,
  parameter int AVG_W  = 3,
  parameter int CFG_W  = 16,
  localparam int CHW   = $clog2(NCH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NCH-1:0]       chan_en_i,
  input  logic [NCH*CFG_W-1:0] chan_cfg_i,
  input  logic [4*APT_W-1:0]   apt_time_i,
  input  logic [AVG_W-1:0]     avg_log2_i,
  input  logic                 avg_ilv_i,
  input  logic [1:0]           trig_mode_i,
  input  logic                 fw_start_i,
  input  logic                 fw_stop_i,
  input  logic                 cont_i,
  input  logic                 hw_trig_i,
  input  logic                 conv_done_i,
  output logic                 conv_start_o,
  output logic                 sample_o,
  output logic [CHW-1:0]       chan_o,
  output logic [ADDR_W-1:0]    pos_addr_o,
  output logic [ADDR_W-1:0]    neg_addr_o,
  output logic                 diff_o,
  output logic                 busy_o,
  output logic                 eos_o,
  output logic                 collision_o
);
  localparam int REP_W   = (1 << AVG_W) + 1;
  localparam int NEG_LSB = POS_LSB + ADDR_W;

  scan_st_e        st_q, st_d;
  logic [CHW-1:0]  chan_q, chan_d;
  logic [REP_W-1:0] rep_q, rep_d, reps_cur;
  logic            eos_q, eos_d, enter_sample;
  logic            first_found, nxt_found, last_rep, scan_end;
  logic [CHW-1:0]  first_idx, nxt_idx;
  logic            idle_go, restart, tmr_last;
  logic [CFG_W-1:0] cfg_cur, cfg_tgt;
  logic [APT_W-1:0] apt_raw, load_val;

  scan_next_chan #(.NCH(NCH)) u_first (
    .mask_i(chan_en_i), .from_i('0), .found_o(first_found), .idx_o(first_idx));

  scan_next_chan #(.NCH(NCH)) u_next (
    .mask_i(chan_en_i), .from_i({1'b0, chan_q} + 1'b1), .found_o(nxt_found), .idx_o(nxt_idx));

  assign cfg_cur  = chan_cfg_i[int'(chan_q)*CFG_W +: CFG_W];
  assign reps_cur = (cfg_cur[AVG_BIT] && !avg_ilv_i) ? (REP_W'(2) << avg_log2_i) : REP_W'(1);
  assign last_rep = (rep_q == reps_cur - 1'b1);
  assign scan_end = (st_q == ST_WAIT) && conv_done_i && last_rep && !nxt_found;

  scan_trig_ctrl u_trig (
    .clk_i, .rst_ni, .trig_mode_i, .fw_start_i, .fw_stop_i, .cont_i, .hw_trig_i,
    .busy_i(st_q != ST_IDLE), .scan_end_i(scan_end),
    .idle_go_o(idle_go), .restart_o(restart), .collision_o(collision_o));

  always_comb begin
    st_d         = st_q;
    chan_d       = chan_q;
    rep_d        = rep_q;
    eos_d        = 1'b0;
    enter_sample = 1'b0;
    unique case (st_q)
      ST_IDLE: if (idle_go) begin
        if (first_found) begin
          st_d = ST_SAMPLE; chan_d = first_idx; rep_d = '0; enter_sample = 1'b1;
        end else begin
          eos_d = 1'b1;
        end
      end
      ST_SAMPLE: if (tmr_last) st_d = ST_START;
      ST_START:  st_d = ST_WAIT;
      ST_WAIT: if (conv_done_i) begin
        if (!last_rep) begin
          rep_d = rep_q + 1'b1; st_d = ST_SAMPLE; enter_sample = 1'b1;
        end else if (nxt_found) begin
          chan_d = nxt_idx; rep_d = '0; st_d = ST_SAMPLE; enter_sample = 1'b1;
        end else begin
          eos_d = 1'b1;
          if (restart && first_found) begin
            chan_d = first_idx; rep_d = '0; st_d = ST_SAMPLE; enter_sample = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // aperture of the channel about to be sampled; 0 and 1 clamp to one cycle
  assign cfg_tgt  = chan_cfg_i[int'(chan_d)*CFG_W +: CFG_W];
  assign apt_raw  = apt_time_i[int'(cfg_tgt[APT_SEL_LSB +: 2])*APT_W +: APT_W];
  assign load_val = (apt_raw < APT_W'(2)) ? APT_W'(1) : apt_raw - 1'b1;

  scan_dwell_timer #(.W(APT_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(enter_sample), .val_i(load_val),
    .en_i(st_q == ST_SAMPLE), .last_o(tmr_last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      chan_q <= '0;
      rep_q  <= '0;
      eos_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      chan_q <= chan_d;
      rep_q  <= rep_d;
      eos_q  <= eos_d;
    end
  end

  assign conv_start_o = (st_q == ST_START);
  assign sample_o     = (st_q == ST_SAMPLE);
  assign busy_o       = (st_q != ST_IDLE);
  assign eos_o        = eos_q;
  assign chan_o       = chan_q;
  assign pos_addr_o   = cfg_cur[POS_LSB +: ADDR_W];
  assign diff_o       = cfg_cur[DIFF_BIT];
  always_comb begin
    if (!cfg_cur[DIFF_BIT])     neg_addr_o = '0;
    else if (cfg_cur[PAIR_BIT]) neg_addr_o = cfg_cur[POS_LSB +: ADDR_W] | ADDR_W'(1);
    else                        neg_addr_o = cfg_cur[NEG_LSB +: ADDR_W];
  end
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk
  import adc_scan_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int ADDR_W = 4,
  parameter int CFG_W  = 16,
  localparam int CHW   = $clog2(NCH)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NCH-1:0]       chan_en_i,
  input logic [NCH*CFG_W-1:0] chan_cfg_i,
  input logic                 conv_start_o,
  input logic                 sample_o,
  input logic [CHW-1:0]       chan_o,
  input logic [ADDR_W-1:0]    pos_addr_o,
  input logic [ADDR_W-1:0]    neg_addr_o,
  input logic                 busy_o,
  input logic                 collision_o
);
  logic [CFG_W-1:0] cfg_now;
  assign cfg_now = chan_cfg_i[int'(chan_o)*CFG_W +: CFG_W];

  AST_CHAN_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> chan_en_i[chan_o]); // R1
  AST_SAMPLE_THEN_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> $past(sample_o)); // R3
  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o); // R3
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> busy_o); // R5
  AST_COLLISION_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collision_o |-> $past(busy_o)); // R7
  AST_PAIRED_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start_o && cfg_now[DIFF_BIT] && cfg_now[PAIR_BIT]) |-> (neg_addr_o == (pos_addr_o | ADDR_W'(1)))); // R12
endmodule

bind adc_scan_seq adc_scan_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .chan_en_i(chan_en_i), .chan_cfg_i(chan_cfg_i),
  .conv_start_o(conv_start_o), .sample_o(sample_o), .chan_o(chan_o),
  .pos_addr_o(pos_addr_o), .neg_addr_o(neg_addr_o), .busy_o(busy_o),
  .collision_o(collision_o));

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [15:0]  chan_en = '0;
  logic [15:0]  cfg [16];
  logic [9:0]   apt [4];
  logic [255:0] cfg_flat;
  logic [39:0]  apt_flat;
  logic [2:0]   avg_log2 = '0;
  logic avg_ilv = 0, fw_start = 0, fw_stop = 0, cont = 0, hw_trig = 0, conv_done = 0;
  logic [1:0] trig_mode = 2'd0;
  logic conv_start, sample, diff, busy, eos, collision;
  logic [3:0] chan, pos, neg;

  always_comb begin
    for (int i = 0; i < 16; i++) cfg_flat[i*16 +: 16] = cfg[i];
    for (int k = 0; k < 4; k++)  apt_flat[k*10 +: 10] = apt[k];
  end

  adc_scan_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .chan_en_i(chan_en), .chan_cfg_i(cfg_flat),
    .apt_time_i(apt_flat), .avg_log2_i(avg_log2), .avg_ilv_i(avg_ilv),
    .trig_mode_i(trig_mode), .fw_start_i(fw_start), .fw_stop_i(fw_stop),
    .cont_i(cont), .hw_trig_i(hw_trig), .conv_done_i(conv_done),
    .conv_start_o(conv_start), .sample_o(sample), .chan_o(chan),
    .pos_addr_o(pos), .neg_addr_o(neg), .diff_o(diff), .busy_o(busy),
    .eos_o(eos), .collision_o(collision));

  typedef struct packed {
    logic [3:0] ch; logic [3:0] pa; logic [3:0] na; logic df; logic [9:0] slen;
  } item_t;
  item_t exp_q[$];

  int checks = 0, fails = 0;
  int eos_cnt = 0, coll_cnt = 0, busy_cnt = 0;
  int scnt = 0;
  string cur_req = "R5";
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  // converter model: done three cycles after start
  int dly = 0;
  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) dly <= 3;
    else if (dly != 0) begin
      dly <= dly - 1;
      if (dly == 1) conv_done <= 1'b1;
    end
  end

  // monitor: pops expected conversions in order
  always @(negedge clk) begin
    if (!rst_n) scnt = 0;
    else begin
      if (eos) eos_cnt++;
      if (collision) coll_cnt++;
      if (busy) busy_cnt++;
      if (conv_start) begin
        item_t act, e;
        act = '{ch: chan, pa: pos, na: neg, df: diff, slen: 10'(scnt)};
        if (exp_q.size() == 0) chk(0, cur_req, "unexpected conversion", 64'(act), 0);
        else begin
          e = exp_q.pop_front();
          chk(act == e, cur_req, "conversion {ch,pos,neg,diff,slen}", 64'(act), 64'(e));
        end
        scnt = 0;
      end else if (sample) scnt++;
    end
  end

  // expected conversions for one scan, from the requirements
  task automatic push_scan();
    for (int ch = 0; ch < 16; ch++) begin
      if (chan_en[ch]) begin
        item_t it;
        logic [15:0] c;
        logic [9:0] a;
        int reps;
        c = cfg[ch];
        a = apt[c[1:0]];
        it.ch = 4'(ch);
        it.pa = c[11:8];
        it.df = c[2];
        it.na = !c[2] ? 4'd0 : (c[3] ? (c[11:8] | 4'd1) : c[15:12]);
        it.slen = (a < 2) ? 10'd1 : a - 10'd1;
        reps = (c[4] && !avg_ilv) ? (2 << avg_log2) : 1;
        for (int r = 0; r < reps; r++) exp_q.push_back(it);
      end
    end
  endtask

  task automatic clr();
    @(posedge clk);
    eos_cnt = 0; coll_cnt = 0; busy_cnt = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); fw_start = 1'b1;
    @(negedge clk); fw_start = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int t = 0; t < 20000 && quiet < 8; t++) begin
      @(posedge clk);
      if (!busy && dly == 0) quiet++; else quiet = 0;
    end
  endtask

  task automatic end_checks(input string req, input int eos_exp);
    chk(eos_cnt == eos_exp, req, "end-of-scan count", 64'(eos_cnt), 64'(eos_exp));
    chk(exp_q.size() == 0, req, "conversions left over", 64'(exp_q.size()), 0);
    chk(busy == 1'b0, req, "busy after scan", 64'(busy), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) cfg[i] = 16'h0000;
    apt[0] = 10'd5; apt[1] = 10'd8; apt[2] = 10'd3; apt[3] = 10'd0;
    cfg[0]  = 16'h0300;            // single-ended pos 3, apt0
    cfg[2]  = 16'h6505;            // unpaired diff pos 5 neg 6, apt1
    cfg[5]  = 16'h940E;            // paired pos 4, neg field 9 ignored, apt2
    cfg[13] = 16'h0703;            // single-ended pos 7, apt3 (=0)
    cfg[15] = 16'h0201;            // apt1
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    chk(!busy && !eos && !conv_start && !collision, "R5", "reset outputs",
        64'({busy, eos, conv_start, collision}), 0);

    // R1 R2 R4 R12 R3: mixed channels, clamped aperture
    cur_req = "R1 R2 R3 R4 R12";
    chan_en = 16'b1010_0000_0010_0101;
    push_scan(); clr(); pulse_start(); wait_idle();
    end_checks("R5", 1);

    // R3 aperture value 1
    cur_req = "R3";
    apt[3] = 10'd1;
    push_scan(); clr(); pulse_start(); wait_idle();
    end_checks("R3", 1);

    // R11 sequential averaging, four repeats on ch0
    cur_req = "R11";
    cfg[0] = 16'h0310; avg_log2 = 3'd1;
    push_scan(); clr(); pulse_start(); wait_idle();
    end_checks("R11", 1);
    avg_ilv = 1'b1;
    push_scan(); clr(); pulse_start(); wait_idle();
    end_checks("R11", 1);
    avg_ilv = 1'b0; cfg[0] = 16'h0300;

    // R13 zero mask
    cur_req = "R13";
    chan_en = '0;
    clr(); pulse_start(); wait_idle();
    chk(eos_cnt == 1, "R13", "eos for empty scan", 64'(eos_cnt), 1);
    chk(busy_cnt == 0, "R13", "busy cycles for empty scan", 64'(busy_cnt), 0);

    // R7 collision and deferral
    cur_req = "R7";
    chan_en = 16'h0025;
    push_scan(); push_scan(); clr(); pulse_start();
    repeat (10) @(posedge clk);
    pulse_start(); wait_idle();
    chk(coll_cnt == 1, "R7", "collision pulses", 64'(coll_cnt), 1);
    end_checks("R7", 2);

    // R10 firmware-only mode ignores hardware trigger
    cur_req = "R10";
    trig_mode = 2'd0;
    clr();
    @(negedge clk); hw_trig = 1'b1;
    repeat (6) @(negedge clk); hw_trig = 1'b0;
    repeat (20) @(negedge clk);
    chk(eos_cnt == 0 && busy_cnt == 0, "R10", "activity from hw trigger",
        64'({eos_cnt[15:0], busy_cnt[15:0]}), 0);

    // R8 edge mode: one scan per edge
    cur_req = "R8";
    trig_mode = 2'd1;
    push_scan(); clr();
    @(negedge clk); hw_trig = 1'b1;
    repeat (150) @(negedge clk); hw_trig = 1'b0;
    wait_idle();
    end_checks("R8", 1);

    // R9 level mode: repeat while high
    cur_req = "R9";
    trig_mode = 2'd2;
    chan_en = 16'h000A;
    cfg[1] = 16'h0100; cfg[3] = 16'h0202;
    push_scan(); push_scan(); push_scan(); clr();
    @(negedge clk); hw_trig = 1'b1;
    for (int t = 0; t < 5000 && eos_cnt < 2; t++) @(posedge clk);
    @(negedge clk); hw_trig = 1'b0;
    wait_idle();
    end_checks("R9", 3);

    // R6 continuous mode, start ignored, stop at boundary
    cur_req = "R6";
    trig_mode = 2'd0;
    push_scan(); push_scan(); push_scan(); clr();
    @(negedge clk); cont = 1'b1; fw_start = 1'b1;
    @(negedge clk); fw_start = 1'b0; cont = 1'b0;
    for (int t = 0; t < 5000 && eos_cnt < 1; t++) @(posedge clk);
    pulse_start();
    for (int t = 0; t < 5000 && eos_cnt < 2; t++) @(posedge clk);
    @(negedge clk); fw_stop = 1'b1;
    @(negedge clk); fw_stop = 1'b0;
    wait_idle();
    chk(coll_cnt == 0, "R6", "collision in continuous mode", 64'(coll_cnt), 0);
    end_checks("R6", 3);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule